// File: doc/BRIEF.md
# Split-Phase Bus Memory Slave

This block is a storage target on a simple two-bit command bus. On every rising clock edge it samples a command, a 16-bit address and a 32-bit write word. A write command stores the word. A read command captures the addressed word at that same edge and presents it in the next cycle. The bus master marks that next cycle with the data command. Idle and data commands leave storage alone and keep the read port released.

The read port is meant for use inside a chip. A released port shows an output-enable of zero and an all-zero word, so no tri-state net is needed. The block also checks each bus field for unknown bits. A field counts as unknown when its integrity flag from the fabric is set, or when it carries X or Z in a four-state simulation. Such a command raises a one-cycle error pulse with a cause code. Storage depth and the value returned for words never written are parameters.

Top module: `split_bus_mem`

## Requirements
- R1: While reset is active and in the first cycle after it, rd_oe is 0, rd_data is 0, err_pulse is 0 and err_cause is 0. Every stored word is marked unwritten.
- R2: A write (cmd 1) with a known command, address and data stores the data at the word selected by the low log2(DEPTH) address bits. Two addresses that share those bits refer to the same word.
- R3: A read (cmd 2) accepted at a clock edge gives rd_oe = 1 for the following cycle only, with rd_data equal to the word held at that edge. Whenever rd_oe is 0, rd_data is 0.
- R4: Idle (cmd 0) and data (cmd 3) change no stored word, give rd_oe = 0 in the next cycle, and raise no error.
- R5: Reading a word that has never been written returns 0. With parameter UNINIT_X = 1 it returns all-X instead.
- R6: An unknown command raises an error with cause code 1 in the next cycle, gives rd_oe = 0 in that cycle, and changes no stored word.
- R7: A write whose address is unknown is discarded and raises cause code 2.
- R8: A write whose address is known but whose data is unknown is discarded and raises cause code 3.
- R9: A read whose address is unknown gives rd_oe = 1 in the next cycle, with rd_data all-X, and raises cause code 2.
- R10: err_pulse is high in exactly the cycle that follows each offending command, and err_cause is 0 whenever err_pulse is 0. When several fields are unknown, the cause follows the priority command, then address, then data. Unknown data on a read is not an error.
- R11: A stored word keeps its value until the next accepted write to it, and the latest accepted write wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock; all sampling on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_cmd | input | 2 | Command: 0 idle, 1 write, 2 read, 3 data |
| bus_addr | input | 16 | Word address |
| bus_wdata | input | 32 | Write word |
| cmd_unk | input | 1 | Fabric flag: command bits unknown |
| addr_unk | input | 1 | Fabric flag: address bits unknown |
| wdata_unk | input | 1 | Fabric flag: write data bits unknown |
| rd_data | output | 32 | Read word, valid while rd_oe is high, else 0 |
| rd_oe | output | 1 | Read port enable for the data cycle |
| err_pulse | output | 1 | One-cycle error indication |
| err_cause | output | 2 | 0 none, 1 command, 2 address, 3 data |

## Verification
The properties assume that the unknown flags alone stand for bad fields. They also assume the command, address and data pins carry two-state values whenever their flags are low, because an X on a pin makes an antecedent undecided. The stimulus follows this. It drives only defined values onto the pins and injects faults by raising the flags, sometimes several at once, so that the priority order is exercised. Addresses span the full 16-bit range, which makes aliasing onto the small store frequent. Read-data values are not compared for reads with an unknown address, since a two-state simulator cannot show X.

// File: rtl/sbm_pkg.sv
package sbm_pkg;

   typedef enum logic [1:0] {
      CMD_IDLE  = 2'd0,
      CMD_WRITE = 2'd1,
      CMD_READ  = 2'd2,
      CMD_DATA  = 2'd3
   } bus_cmd_e;

   typedef enum logic [1:0] {
      CAUSE_NONE = 2'd0,
      CAUSE_CMD  = 2'd1,
      CAUSE_ADDR = 2'd2,
      CAUSE_DATA = 2'd3
   } err_cause_e;

   // decoded action for one sampled bus cycle
   typedef struct packed {
      logic       wr_en;
      logic       rd_en;
      logic       rd_x;
      logic       err;
      err_cause_e cause;
   } bus_op_t;

endpackage

// File: rtl/sbm_decode.sv
module sbm_decode
   import sbm_pkg::*;
#(
   parameter int ADDR_W = 16,
   parameter int DATA_W = 32
) (
   input  logic [1:0]        cmd,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   input  logic              cmd_unk,
   input  logic              addr_unk,
   input  logic              wdata_unk,
   output bus_op_t           op
);

   logic cmd_bad, addr_bad, data_bad;

   // a field is bad if the fabric flags it or it holds X/Z bits
   always_comb begin
      cmd_bad  = cmd_unk   | $isunknown(cmd);
      addr_bad = addr_unk  | $isunknown(addr);
      data_bad = wdata_unk | $isunknown(wdata);
   end

   always_comb begin
      op = '0;
      if (cmd_bad) begin
         op.err   = 1'b1;
         op.cause = CAUSE_CMD;
      end else begin
         unique case (bus_cmd_e'(cmd))
            CMD_WRITE: begin
               if (addr_bad) begin
                  op.err   = 1'b1;
                  op.cause = CAUSE_ADDR;
               end else if (data_bad) begin
                  op.err   = 1'b1;
                  op.cause = CAUSE_DATA;
               end else begin
                  op.wr_en = 1'b1;
               end
            end
            CMD_READ: begin
               op.rd_en = 1'b1;
               if (addr_bad) begin
                  op.rd_x  = 1'b1;
                  op.err   = 1'b1;
                  op.cause = CAUSE_ADDR;
               end
            end
            default: begin
               op = '0;
            end
         endcase
      end
   end

endmodule

// File: rtl/sbm_store.sv
module sbm_store #(
   parameter int DATA_W   = 32,
   parameter int DEPTH    = 16,
   parameter bit UNINIT_X = 1'b0,
   localparam int IDX_W   = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [IDX_W-1:0]  wr_idx,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [IDX_W-1:0]  rd_idx,
   output logic [DATA_W-1:0] rd_word
);

   logic [DEPTH*DATA_W-1:0] flat;
   logic [DEPTH-1:0]        vld;
   logic [DATA_W-1:0]       fill_w;

   for (genvar i = 0; i < DEPTH; i++) begin : g_word
      logic [DATA_W-1:0] word_q;
      logic              vld_q;
      logic              hit;

      assign hit = wr_en && (wr_idx == IDX_W'(i));

      always_ff @(posedge clk) begin
         if (hit) word_q <= wr_data;
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)   vld_q <= 1'b0;
         else if (hit) vld_q <= 1'b1;
      end

      assign flat[i*DATA_W +: DATA_W] = word_q;
      assign vld[i]                   = vld_q;
   end

   if (UNINIT_X) begin : g_fill_x
      assign fill_w = {DATA_W{1'bx}};
   end else begin : g_fill_zero
      assign fill_w = '0;
   end

   always_comb begin
      rd_word = vld[rd_idx] ? flat[rd_idx*DATA_W +: DATA_W] : fill_w;
   end

endmodule

// File: rtl/sbm_outreg.sv
module sbm_outreg
   import sbm_pkg::*;
#(
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  bus_op_t           op,
   input  logic [DATA_W-1:0] rd_word,
   output logic [DATA_W-1:0] rd_data,
   output logic              rd_oe,
   output logic              err_pulse,
   output logic [1:0]        err_cause
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_oe     <= 1'b0;
         rd_data   <= '0;
         err_pulse <= 1'b0;
         err_cause <= CAUSE_NONE;
      end else begin
         rd_oe     <= op.rd_en;
         err_pulse <= op.err;
         err_cause <= op.err ? op.cause : CAUSE_NONE;
         if (!op.rd_en)    rd_data <= '0;
         else if (op.rd_x) rd_data <= {DATA_W{1'bx}};
         else              rd_data <= rd_word;
      end
   end

endmodule

// File: rtl/split_bus_mem.sv
module split_bus_mem
   import sbm_pkg::*;
#(
   parameter int ADDR_W   = 16,
   parameter int DATA_W   = 32,
   parameter int DEPTH    = 16,
   parameter bit UNINIT_X = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [1:0]        bus_cmd,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   input  logic              cmd_unk,
   input  logic              addr_unk,
   input  logic              wdata_unk,
   output logic [DATA_W-1:0] rd_data,
   output logic              rd_oe,
   output logic              err_pulse,
   output logic [1:0]        err_cause
);

   localparam int IDX_W = $clog2(DEPTH);

   if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("DEPTH must be a power of two of at least 2");
   end
   if (IDX_W > ADDR_W) begin : g_bad_addr
      $error("DEPTH exceeds the address space");
   end
   if (DATA_W < 1) begin : g_bad_data
      $error("DATA_W must be positive");
   end

   bus_op_t           op;
   logic [DATA_W-1:0] rd_word;
   logic [IDX_W-1:0]  idx;

   assign idx = bus_addr[IDX_W-1:0];

   sbm_decode #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_decode (
      .cmd       (bus_cmd),
      .addr      (bus_addr),
      .wdata     (bus_wdata),
      .cmd_unk   (cmd_unk),
      .addr_unk  (addr_unk),
      .wdata_unk (wdata_unk),
      .op        (op)
   );

   sbm_store #(.DATA_W(DATA_W), .DEPTH(DEPTH), .UNINIT_X(UNINIT_X)) u_store (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (op.wr_en),
      .wr_idx  (idx),
      .wr_data (bus_wdata),
      .rd_idx  (idx),
      .rd_word (rd_word)
   );

   sbm_outreg #(.DATA_W(DATA_W)) u_out (
      .clk       (clk),
      .rst_n     (rst_n),
      .op        (op),
      .rd_word   (rd_word),
      .rd_data   (rd_data),
      .rd_oe     (rd_oe),
      .err_pulse (err_pulse),
      .err_cause (err_cause)
   );

endmodule

// File: rtl/sbm_checker.sv
module sbm_checker #(
   parameter int ADDR_W = 16,
   parameter int DATA_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic [1:0]        bus_cmd,
   input logic [ADDR_W-1:0] bus_addr,
   input logic              cmd_unk,
   input logic              addr_unk,
   input logic              wdata_unk,
   input logic [DATA_W-1:0] rd_data,
   input logic              rd_oe,
   input logic              err_pulse,
   input logic [1:0]        err_cause
);

   assert_oe_after_read_R3: assert property (@(posedge clk) disable iff (!rst_n)
      rd_oe |-> $past(bus_cmd == 2'd2 && !cmd_unk));

   assert_released_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_oe |-> rd_data == '0);

   assert_idle_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (!cmd_unk && (bus_cmd == 2'd0 || bus_cmd == 2'd3)) |=> (!rd_oe && !err_pulse));

   assert_cmd_error_R6: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_unk |=> (err_pulse && err_cause == 2'd1 && !rd_oe));

   assert_wr_addr_error_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (!cmd_unk && bus_cmd == 2'd1 && addr_unk) |=> (err_pulse && err_cause == 2'd2));

   assert_wr_data_error_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (!cmd_unk && bus_cmd == 2'd1 && !addr_unk && wdata_unk) |=> (err_pulse && err_cause == 2'd3));

   assert_rd_addr_error_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (!cmd_unk && bus_cmd == 2'd2 && addr_unk) |=> (rd_oe && err_pulse && err_cause == 2'd2));

   assert_cause_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !err_pulse |-> err_cause == 2'd0);

   assert_read_data_ok_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (!cmd_unk && bus_cmd == 2'd2 && !addr_unk) |=> !err_pulse);

   logic unused_ok;
   assign unused_ok = ^bus_addr;

endmodule

bind split_bus_mem sbm_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_cmd   (bus_cmd),
   .bus_addr  (bus_addr),
   .cmd_unk   (cmd_unk),
   .addr_unk  (addr_unk),
   .wdata_unk (wdata_unk),
   .rd_data   (rd_data),
   .rd_oe     (rd_oe),
   .err_pulse (err_pulse),
   .err_cause (err_cause)
);

// File: tb/tb_split_bus_mem.sv
`timescale 1ns/1ps
module tb_split_bus_mem;

   localparam int DEPTH = 16;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [1:0]  bus_cmd = 2'd0;
   logic [15:0] bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic        cmd_unk = 1'b0, addr_unk = 1'b0, wdata_unk = 1'b0;
   logic [31:0] rd_data;
   logic        rd_oe, err_pulse;
   logic [1:0]  err_cause;

   int errs = 0;
   int checks = 0;
   bit done = 1'b0;

   logic [31:0] ref_mem [DEPTH];
   bit          ref_vld [DEPTH];

   always #2 clk = ~clk;

   split_bus_mem dut (
      .clk(clk), .rst_n(rst_n), .bus_cmd(bus_cmd), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .cmd_unk(cmd_unk), .addr_unk(addr_unk),
      .wdata_unk(wdata_unk), .rd_data(rd_data), .rd_oe(rd_oe),
      .err_pulse(err_pulse), .err_cause(err_cause)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errs++;
         $display("FAIL %s: actual=%h expected=%h at %0t", tag, act, exp, $time);
      end
   endtask

   function automatic logic [1:0] exp_cause(input logic [1:0] c, input bit cu, au, du);
      if (cu) return 2'd1;
      if ((c == 2'd1 || c == 2'd2) && au) return 2'd2;
      if (c == 2'd1 && du) return 2'd3;
      return 2'd0;
   endfunction

   function automatic logic [31:0] exp_word(input logic [15:0] a);
      int i = int'(a[3:0]);
      return ref_vld[i] ? ref_mem[i] : 32'h0;
   endfunction

   // drive at falling edge, let one rising edge pass, check at next falling edge
   task automatic step(input logic [1:0] c, input logic [15:0] a, input logic [31:0] d,
                       input bit cu, input bit au, input bit du, input string tag);
      logic [1:0]  ec;
      bit          eoe;
      logic [31:0] ed;
      bus_cmd = c; bus_addr = a; bus_wdata = d;
      cmd_unk = cu; addr_unk = au; wdata_unk = du;
      ec  = exp_cause(c, cu, au, du);
      eoe = !cu && c == 2'd2;
      ed  = eoe ? exp_word(a) : 32'h0;
      @(posedge clk);
      @(negedge clk);
      chk({tag, " rd_oe"}, {31'b0, rd_oe}, {31'b0, eoe});
      if (!(eoe && au)) chk({tag, " rd_data"}, rd_data, ed);
      chk({tag, " err_pulse"}, {31'b0, err_pulse}, {31'b0, ec != 2'd0});
      chk({tag, " err_cause"}, {30'b0, err_cause}, {30'b0, ec});
      if (!cu && c == 2'd1 && !au && !du) begin
         ref_mem[int'(a[3:0])] = d;
         ref_vld[int'(a[3:0])] = 1'b1;
      end
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      if (!done) begin
         errs++;
         checks++;
         $display("FAIL watchdog: actual=running expected=finished");
         $display("Result: errors=%0d of %0d checks", errs, checks);
         $finish;
      end
   end

   initial begin : main
      int seed;
      for (int i = 0; i < DEPTH; i++) begin ref_vld[i] = 1'b0; ref_mem[i] = '0; end
      seed = $urandom(32'd4321);
      repeat (3) @(negedge clk);
      // R1 reset state
      chk("R1 oe in reset", {31'b0, rd_oe}, 32'd0);
      chk("R1 data in reset", rd_data, 32'd0);
      chk("R1 err in reset", {29'b0, err_pulse, err_cause}, 32'd0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 after reset", {29'b0, rd_oe, err_pulse, err_cause[0]}, 32'd0);

      // R5 unwritten read returns zero
      step(2'd2, 16'h0005, '0, 0, 0, 0, "R5 unwritten read");
      // R2 / R3 write then read, read followed by DATA cycle
      step(2'd1, 16'h0005, 32'hCAFE_0005, 0, 0, 0, "R2 write");
      step(2'd2, 16'h0005, '0, 0, 0, 0, "R3 read");
      step(2'd3, 16'h0005, '0, 0, 0, 0, "R3 data cycle release");
      // R2 aliasing: 0x1237 maps to word 7
      step(2'd1, 16'h1237, 32'h1111_2222, 0, 0, 0, "R2 alias write");
      step(2'd2, 16'h0007, '0, 0, 0, 0, "R2 alias read");
      // R4 idle/data with write data on the pins change nothing
      step(2'd0, 16'h0007, 32'hDEAD_BEEF, 0, 0, 0, "R4 idle");
      step(2'd3, 16'h0007, 32'hDEAD_BEEF, 0, 0, 0, "R4 data");
      step(2'd2, 16'h0007, '0, 0, 0, 0, "R4 word kept");
      // R6 unknown command with a write pattern
      step(2'd1, 16'h0007, 32'h5555_5555, 1, 0, 0, "R6 unknown cmd");
      step(2'd2, 16'h0007, '0, 0, 0, 0, "R6 no write");
      // R7 unknown address write
      step(2'd1, 16'h0007, 32'h6666_6666, 0, 1, 0, "R7 addr unknown write");
      step(2'd2, 16'h0007, '0, 0, 0, 0, "R7 discarded");
      // R8 unknown data write
      step(2'd1, 16'h0007, 32'h7777_7777, 0, 0, 1, "R8 data unknown write");
      step(2'd2, 16'h0007, '0, 0, 0, 0, "R8 discarded");
      // R9 read with unknown address
      step(2'd2, 16'h0007, '0, 0, 1, 0, "R9 read addr unknown");
      // R10 priority and read with unknown data, back-to-back errors
      step(2'd1, 16'h0003, 32'h1, 1, 1, 1, "R10 prio cmd");
      step(2'd1, 16'h0003, 32'h1, 0, 1, 1, "R10 prio addr");
      step(2'd2, 16'h0007, 32'h1, 0, 0, 1, "R10 read data flag ignored");
      step(2'd0, 16'h0000, '0, 0, 0, 0, "R10 pulse ends");
      // R11 latest write wins
      step(2'd1, 16'h0009, 32'hAAAA_0001, 0, 0, 0, "R11 write 1");
      step(2'd1, 16'h0019, 32'hAAAA_0002, 0, 0, 0, "R11 write 2");
      step(2'd2, 16'h0009, '0, 0, 0, 0, "R11 read latest");

      // constrained random traffic
      for (int n = 0; n < 600; n++) begin
         logic [1:0] c = 2'($urandom_range(0, 3));
         bit cu = ($urandom_range(0, 15) == 0);
         bit au = ($urandom_range(0, 7) == 0);
         bit du = ($urandom_range(0, 7) == 0);
         string tg;
         if (cu)                           tg = "R6 rand";
         else if (c == 2'd1 && au)         tg = "R7 rand";
         else if (c == 2'd1 && du)         tg = "R8 rand";
         else if (c == 2'd1)               tg = "R2 rand";
         else if (c == 2'd2 && au)         tg = "R9 rand";
         else if (c == 2'd2)               tg = "R11 rand";
         else                              tg = "R4 rand";
         step(c, 16'($urandom), $urandom, cu, au, du, tg);
      end

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
   end

endmodule